// File: doc/BRIEF.md
# Doorbell Circular-Buffer Mailbox

This block is a small memory-mapped mailbox that connects a host processor to an embedded controller. There is one circular buffer of 32-bit slots in each direction. The host sees four word registers:

- **0x00, downstream window.** A write pushes one slot toward the controller.
- **0x04, host status/control word.** It describes the downstream buffer and holds the host's control bits.
- **0x08, upstream window.** A read pops one slot that the controller produced.
- **0x0C, controller status word.** It is read-only and describes the upstream buffer.

The controller side is a plain push/pop port. It has a show-ahead head word and a room count. It also has a doorbell pulse input toward the host and a pending-doorbell flag from the host.

Both status words share one packing:

| Bits | Field |
|------|-------|
| 0 | interrupt enable |
| 1 | interrupt status |
| 2 | doorbell generate (reads 0) |
| 3 | ready |
| 4 | reset |
| 5 | sticky overflow |
| 15:8 | read pointer |
| 23:16 | write pointer |
| 31:24 | depth in slots |

The pointers run freely modulo 256. Software derives the used slots as (write − read) mod 256 and the free slots as depth minus that value. The reset bit starts a resynchronisation: the host sets reset together with the doorbell, waits for the controller to report ready, then clears reset and sets ready.

Read data is registered. It appears on `h_rdata` one clock after the read strobe. The depth is a power of two from 2 to 128, so that a free-running 8-bit pointer taken modulo the depth always indexes the storage correctly.

Top module: `mbox_top`

## Requirements
- R1: After reset, the host word (0x04) and the controller word (0x0C) both read DEPTH<<24, given c_ready low. In both words every control bit and both pointers are 0, and h_irq is low.
- R2: Each write to 0x00 stores one slot and increments the host-word write pointer (bits 23:16). The controller receives the slots in write order on c_dn_data while c_dn_valid is high. Each c_pop increments the read pointer (bits 15:8).
- R3: A write to 0x00 while DEPTH slots are already held is dropped and sets overflow (bit 5 of 0x04). The flag stays set until the host writes 1 to bit 5 of 0x04.
- R4: Each c_push stores one slot toward the host. Reads of 0x08 return those slots in order and advance the read pointer of 0x0C; c_push advances its write pointer.
- R5: A read of 0x08 with the upstream buffer empty returns 0 and changes neither pointer of 0x0C.
- R6: The pointers wrap modulo 256 independently of DEPTH. After N slots pass through, both pointers read N mod 256, and DEPTH − ((wp − rp) mod 256) equals the free slot count.
- R7: A c_ring pulse sets interrupt status (bit 1 of 0x04). h_irq equals interrupt enable (bit 0) AND interrupt status. Writing 1 to bit 1 clears the status.
- R8: Writing 0x04 with bit 2 set raises c_db_pending, which stays high until c_db_clr. Bit 2 always reads 0.
- R9: While reset (bit 4 of 0x04) is set: both buffers read empty with pointers 0, ready (bit 3 of 0x04) reads 0, bit 3 of 0x0C reads 0 whatever c_ready is, and writes to 0x00 are ignored.
- R10: Writing 0x04 with reset 0 and ready 1 makes bit 3 of 0x04 read 1. Bit 3 of 0x0C then follows c_ready.
- R11: Writes to 0x0C and 0x08 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_addr | input | 4 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one clock after the strobe |
| h_irq | output | 1 | Host interrupt |
| c_ready | input | 1 | Controller reports ready |
| c_ring | input | 1 | Controller doorbell pulse toward host |
| c_push | input | 1 | Controller pushes a slot toward host |
| c_push_data | input | 32 | Slot pushed by controller |
| c_up_room | output | 8 | Free slots toward host |
| c_pop | input | 1 | Controller consumes head slot |
| c_dn_valid | output | 1 | Head slot from host is present |
| c_dn_data | output | 32 | Head slot from host |
| c_db_pending | output | 1 | Host doorbell waiting for the controller |
| c_db_clr | input | 1 | Controller acknowledges the doorbell |

## Verification
A corrupted pointer surfaces at the ports within one clock. The status word read two clocks after the pointer fault shows a wrong write-minus-read distance, and the next slot popped on either side is stale or out of order. A lost flush or a lost overflow flag is visible on the very next status read. A missed doorbell appears as h_irq or c_db_pending staying low in the cycle after the pulse.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int PTR_W  = 8;
    localparam int SLOT_W = 32;

    typedef enum logic [1:0] {
        SEL_DN_WIN = 2'd0,
        SEL_HWORD  = 2'd1,
        SEL_UP_WIN = 2'd2,
        SEL_CWORD  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PTR_W-1:0] depth;
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [1:0]       rsvd;
        logic             ovf;
        logic             rst;
        logic             ready;
        logic             ring;
        logic             stat;
        logic             en;
    } ctl_word_t;

    function automatic logic [SLOT_W-1:0] pack_word(
        input logic [PTR_W-1:0] depth,
        input logic [PTR_W-1:0] wp,
        input logic [PTR_W-1:0] rp,
        input logic             ovf,
        input logic             rst,
        input logic             ready,
        input logic             stat,
        input logic             en
    );
        ctl_word_t w;
        w.depth = depth;
        w.wp    = wp;
        w.rp    = rp;
        w.rsvd  = 2'b00;
        w.ovf   = ovf;
        w.rst   = rst;
        w.ready = ready;
        w.ring  = 1'b0;
        w.stat  = stat;
        w.en    = en;
        return w;
    endfunction

    function automatic bit depth_ok(input int d);
        return (d >= 2) && (d <= 128) && ((d & (d - 1)) == 0);
    endfunction

endpackage

// File: rtl/mbox_ring.sv
module mbox_ring
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [PTR_W-1:0] rp,
    output logic [PTR_W-1:0] wp,
    output logic [PTR_W-1:0] used,
    output logic             empty,
    output logic             full,
    output logic             drop
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign used    = wp - rp;
    assign empty   = (used == '0);
    assign full    = (used == DEPTH_P);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign drop    = push && full && !flush;
    assign head    = mem[rp[IW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rp <= '0;
            wp <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp[IW-1:0]] <= push_data;
    end

endmodule

// File: rtl/mbox_hctl.sv
module mbox_hctl
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_wr,
    input  logic [SLOT_W-1:0] wdata,
    input  logic              ring_in,
    input  logic              ovf_evt,
    input  logic              db_clr,
    output logic              en_q,
    output logic              stat_q,
    output logic              ready_q,
    output logic              hrst_q,
    output logic              ovf_q,
    output logic              db_q
);
    ctl_word_t w;
    assign w = ctl_word_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            stat_q  <= 1'b0;
            ready_q <= 1'b0;
            hrst_q  <= 1'b0;
            ovf_q   <= 1'b0;
            db_q    <= 1'b0;
        end else begin
            if (word_wr) begin
                en_q    <= w.en;
                hrst_q  <= w.rst;
                ready_q <= w.rst ? 1'b0 : w.ready;
            end
            // set wins over write-one-to-clear
            stat_q <= ring_in || (stat_q && !(word_wr && w.stat));
            if (hrst_q)
                ovf_q <= 1'b0;
            else
                ovf_q <= ovf_evt || (ovf_q && !(word_wr && w.ovf));
            db_q <= (word_wr && w.ring) || (db_q && !db_clr);
        end
    end

endmodule

// File: rtl/mbox_top.sv
module mbox_top
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        h_wr_en,
    input  logic        h_rd_en,
    input  logic [3:0]  h_addr,
    input  logic [31:0] h_wdata,
    output logic [31:0] h_rdata,
    output logic        h_irq,
    input  logic        c_ready,
    input  logic        c_ring,
    input  logic        c_push,
    input  logic [31:0] c_push_data,
    output logic [7:0]  c_up_room,
    input  logic        c_pop,
    output logic        c_dn_valid,
    output logic [31:0] c_dn_data,
    output logic        c_db_pending,
    input  logic        c_db_clr
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    if (!depth_ok(DEPTH)) begin : g_bad_depth
        $error("mbox_top: DEPTH must be a power of two in 2..128");
    end

    reg_sel_e sel;
    logic wr_win, word_wr, rd_win;
    logic en_q, stat_q, ready_q, hrst_q, ovf_q, db_q;
    logic [SLOT_W-1:0] dn_head, up_head;
    logic [PTR_W-1:0]  dn_rp, dn_wp, dn_used, up_rp, up_wp, up_used;
    logic dn_empty, dn_full, dn_drop, up_empty, up_full, up_drop;

    assign sel     = reg_sel_e'(h_addr[3:2]);
    assign wr_win  = h_wr_en && (sel == SEL_DN_WIN);
    assign word_wr = h_wr_en && (sel == SEL_HWORD);
    assign rd_win  = h_rd_en && (sel == SEL_UP_WIN);

    mbox_hctl u_hctl (
        .clk     (clk),
        .rst     (rst),
        .word_wr (word_wr),
        .wdata   (h_wdata),
        .ring_in (c_ring),
        .ovf_evt (dn_drop),
        .db_clr  (c_db_clr),
        .en_q    (en_q),
        .stat_q  (stat_q),
        .ready_q (ready_q),
        .hrst_q  (hrst_q),
        .ovf_q   (ovf_q),
        .db_q    (db_q)
    );

    mbox_ring #(.DEPTH(DEPTH), .WIDTH(SLOT_W)) u_dn (
        .clk       (clk),
        .rst       (rst),
        .flush     (hrst_q),
        .push      (wr_win),
        .push_data (h_wdata),
        .pop       (c_pop),
        .head      (dn_head),
        .rp        (dn_rp),
        .wp        (dn_wp),
        .used      (dn_used),
        .empty     (dn_empty),
        .full      (dn_full),
        .drop      (dn_drop)
    );

    mbox_ring #(.DEPTH(DEPTH), .WIDTH(SLOT_W)) u_up (
        .clk       (clk),
        .rst       (rst),
        .flush     (hrst_q),
        .push      (c_push),
        .push_data (c_push_data),
        .pop       (rd_win),
        .head      (up_head),
        .rp        (up_rp),
        .wp        (up_wp),
        .used      (up_used),
        .empty     (up_empty),
        .full      (up_full),
        .drop      (up_drop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            h_rdata <= '0;
        end else if (h_rd_en) begin
            unique case (sel)
                SEL_HWORD:  h_rdata <= pack_word(DEPTH_P, dn_wp, dn_rp, ovf_q,
                                                 hrst_q, ready_q, stat_q, en_q);
                SEL_UP_WIN: h_rdata <= (up_empty || hrst_q) ? '0 : up_head;
                SEL_CWORD:  h_rdata <= pack_word(DEPTH_P, up_wp, up_rp, 1'b0, 1'b0,
                                                 c_ready && !hrst_q, db_q, 1'b0);
                default:    h_rdata <= '0;
            endcase
        end
    end

    assign h_irq        = en_q && stat_q;
    assign c_up_room    = DEPTH_P - up_used;
    assign c_dn_valid   = !dn_empty && !hrst_q;
    assign c_dn_data    = dn_head;
    assign c_db_pending = db_q;

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_win,
    input logic        word_wr,
    input logic        rd_win,
    input logic [31:0] h_wdata,
    input logic [31:0] h_rdata,
    input logic [7:0]  dn_used,
    input logic [7:0]  up_used,
    input logic [7:0]  dn_wp,
    input logic        hrst_q,
    input logic        ovf_q,
    input logic        db_q
);
    // R2: occupancy never exceeds the depth
    p_used_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (dn_used <= 8'(DEPTH)) && (up_used <= 8'(DEPTH)));

    // R3: write into a full buffer leaves the write pointer alone and flags it
    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_win && !hrst_q && dn_used == 8'(DEPTH)) |=> ($stable(dn_wp) && ovf_q));

    // R3: overflow flag is sticky until cleared
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !hrst_q && !(word_wr && h_wdata[5])) |=> ovf_q);

    // R5: empty read window returns zero
    p_empty_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_win && up_used == 8'd0) |=> (h_rdata == 32'd0));

    // R9: reset bit flushes both buffers
    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        hrst_q |=> (dn_used == 8'd0 && up_used == 8'd0));

    // R8: doorbell toward the controller is raised
    p_doorbell_r8: assert property (@(posedge clk) disable iff (rst)
        (word_wr && h_wdata[2]) |=> db_q);
endmodule

bind mbox_top mbox_checker #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_win  (wr_win),
    .word_wr (word_wr),
    .rd_win  (rd_win),
    .h_wdata (h_wdata),
    .h_rdata (h_rdata),
    .dn_used (dn_used),
    .up_used (up_used),
    .dn_wp   (dn_wp),
    .hrst_q  (hrst_q),
    .ovf_q   (ovf_q),
    .db_q    (db_q)
);

// File: tb/mbox_top_tb.sv
`timescale 1ns/1ps
module mbox_top_tb;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_wr_en = 0, h_rd_en = 0;
    logic [3:0]  h_addr = 0;
    logic [31:0] h_wdata = 0;
    logic [31:0] h_rdata;
    logic        h_irq;
    logic        c_ready = 0, c_ring = 0, c_push = 0, c_pop = 0, c_db_clr = 0;
    logic [31:0] c_push_data = 0;
    logic [7:0]  c_up_room;
    logic        c_dn_valid, c_db_pending;
    logic [31:0] c_dn_data;

    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] dnq[$], upq[$];
    int dn_n = 0, up_n = 0, dn_r = 0, up_r = 0;

    always #4 clk = ~clk;

    mbox_top #(.DEPTH(D)) u_dut (.*);

    function automatic logic [31:0] word_of(int wp, int rp, bit ovf, bit rs,
                                            bit rdy, bit st, bit en);
        return (32'(D) << 24) | (32'(wp % 256) << 16) | (32'(rp % 256) << 8) |
               (32'(ovf) << 5) | (32'(rs) << 4) | (32'(rdy) << 3) |
               (32'(st) << 1) | 32'(en);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [3:0] a, input logic [31:0] d);
        h_addr = a; h_wdata = d; h_wr_en = 1;
        @(negedge clk); h_wr_en = 0;
    endtask

    task automatic hrd(input logic [3:0] a, output logic [31:0] d);
        h_addr = a; h_rd_en = 1;
        @(negedge clk); h_rd_en = 0; d = h_rdata;
    endtask

    task automatic cpush(input logic [31:0] d);
        c_push_data = d; c_push = 1;
        @(negedge clk); c_push = 0;
    endtask

    task automatic cpop(output logic [31:0] d, output logic v);
        v = c_dn_valid; d = c_dn_data; c_pop = 1;
        @(negedge clk); c_pop = 0;
    endtask

    task automatic pulse_ring();
        c_ring = 1; @(negedge clk); c_ring = 0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    initial begin
        logic [31:0] r, d;
        logic v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        hrd(4'h4, r); check("R1 host word", r, word_of(0, 0, 0, 0, 0, 0, 0));
        hrd(4'hC, r); check("R1 ctrl word", r, word_of(0, 0, 0, 0, 0, 0, 0));
        check("R1 irq", 32'(h_irq), 0);

        // R2 downstream order and pointers
        for (int i = 0; i < 3; i++) begin hwr(4'h0, 32'hA000 + i); dn_n++; end
        hrd(4'h4, r); check("R2 wp", r, word_of(3, 0, 0, 0, 0, 0, 0));
        for (int i = 0; i < 3; i++) begin
            cpop(d, v); dn_r++;
            check("R2 valid", 32'(v), 1);
            check("R2 data", d, 32'hA000 + i);
        end
        hrd(4'h4, r); check("R2 rp", r, word_of(3, 3, 0, 0, 0, 0, 0));

        // R3 overflow drop and sticky flag
        for (int i = 0; i < D + 1; i++) hwr(4'h0, 32'hB000 + i);
        dn_n += D;
        hrd(4'h4, r); check("R3 ovf set", r, word_of(dn_n, dn_r, 1, 0, 0, 0, 0));
        for (int i = 0; i < D; i++) begin
            cpop(d, v); dn_r++;
            check("R3 data", d, 32'hB000 + i);
        end
        check("R3 drained", 32'(c_dn_valid), 0);
        hrd(4'h4, r); check("R3 sticky", r, word_of(dn_n, dn_r, 1, 0, 0, 0, 0));
        hwr(4'h4, 32'h20);
        hrd(4'h4, r); check("R3 clear", r, word_of(dn_n, dn_r, 0, 0, 0, 0, 0));

        // R4 upstream order
        for (int i = 0; i < 4; i++) begin cpush(32'hC000 + i); up_n++; end
        check("R4 room", 32'(c_up_room), D - 4);
        for (int i = 0; i < 4; i++) begin
            hrd(4'h8, r); up_r++;
            check("R4 data", r, 32'hC000 + i);
        end
        hrd(4'hC, r); check("R4 ctrl ptrs", r, word_of(4, 4, 0, 0, 0, 0, 0));

        // R5 empty read
        hrd(4'h8, r); check("R5 zero", r, 0);
        hrd(4'hC, r); check("R5 ptrs", r, word_of(4, 4, 0, 0, 0, 0, 0));

        // R7 interrupt status and enable
        pulse_ring();
        check("R7 masked", 32'(h_irq), 0);
        hrd(4'h4, r); check("R7 status", r, word_of(dn_n, dn_r, 0, 0, 0, 1, 0));
        hwr(4'h4, 32'h1);
        check("R7 irq", 32'(h_irq), 1);
        hwr(4'h4, 32'h3);
        check("R7 w1c", 32'(h_irq), 0);

        // R8 doorbell to controller
        hwr(4'h4, 32'h4);
        check("R8 pending", 32'(c_db_pending), 1);
        hrd(4'h4, r); check("R8 reads 0", r & 32'h4, 0);
        hrd(4'hC, r); check("R8 ctrl stat", r & 32'h2, 32'h2);
        c_db_clr = 1; @(negedge clk); c_db_clr = 0;
        check("R8 cleared", 32'(c_db_pending), 0);

        // R11 writes to read-only / read window ignored
        hwr(4'hC, 32'hFFFF_FFFF);
        hwr(4'h8, 32'hFFFF_FFFF);
        hrd(4'hC, r); check("R11 ctrl word", r, word_of(4, 4, 0, 0, 0, 0, 0));
        hrd(4'h8, r); check("R11 no slot", r, 0);

        // R9 reset handshake flush
        hwr(4'h0, 32'h1); hwr(4'h0, 32'h2); cpush(32'h3);
        c_ready = 1;
        hwr(4'h4, 32'h14);
        @(negedge clk);
        hwr(4'h0, 32'h55);
        hrd(4'h4, r); check("R9 host word", r, word_of(0, 0, 0, 1, 0, 0, 0));
        hrd(4'hC, r); check("R9 ctrl word", r, word_of(0, 0, 0, 0, 0, 1, 0));
        check("R9 dn empty", 32'(c_dn_valid), 0);
        check("R9 up room", 32'(c_up_room), D);
        check("R9 doorbell", 32'(c_db_pending), 1);
        c_db_clr = 1; @(negedge clk); c_db_clr = 0;
        dn_n = 0; dn_r = 0; up_n = 0; up_r = 0;

        // R10 release with ready
        hwr(4'h4, 32'h8);
        hrd(4'h4, r); check("R10 host ready", r, word_of(0, 0, 0, 0, 1, 0, 0));
        hrd(4'hC, r); check("R10 ctrl ready", r, word_of(0, 0, 0, 0, 1, 0, 0));

        // R6 wrap past 256
        for (int i = 0; i < 300; i++) begin
            hwr(4'h0, 32'(i * 7)); dn_n++;
            cpop(d, v); dn_r++;
            if (i % 50 == 0) check("R6 pass data", d, 32'(i * 7));
        end
        hrd(4'h4, r); check("R6 wrap ptrs", r, word_of(300, 300, 0, 0, 1, 0, 0));
        for (int i = 0; i < 3; i++) begin hwr(4'h0, 32'hE0 + i); dnq.push_back(32'hE0 + i); dn_n++; end
        hrd(4'h4, r);
        check("R6 empty count", (r >> 24) - (((r >> 16) - (r >> 8)) & 32'hFF), D - 3);

        // randomized mix against queue model
        for (int k = 0; k < 500; k++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0 && dnq.size() < D) begin
                d = $urandom; hwr(4'h0, d); dnq.push_back(d); dn_n++;
            end else if (op == 1) begin
                cpop(d, v);
                if (dnq.size() > 0) begin
                    check("R2 rand pop", d, dnq.pop_front()); dn_r++;
                end else check("R2 rand empty", 32'(v), 0);
            end else if (op == 2 && upq.size() < D) begin
                d = $urandom; cpush(d); upq.push_back(d); up_n++;
            end else if (op == 3) begin
                hrd(4'h8, r);
                if (upq.size() > 0) begin
                    check("R4 rand read", r, upq.pop_front()); up_r++;
                end else check("R5 rand empty", r, 0);
            end
        end
        hrd(4'h4, r); check("R6 rand host ptrs", r, word_of(dn_n, dn_r, 0, 0, 1, 0, 0));
        hrd(4'hC, r); check("R6 rand ctrl ptrs", r, word_of(up_n, up_r, 0, 0, 1, 0, 0));

        finish_up();
    end
endmodule